// File: doc/BRIEF.md
# Sixteen-bit reload timer/counter with external-interrupt configuration

This peripheral sits beside a small 8-bit processor core. It holds a 16-bit count that advances from one of two sources. The first is a machine-cycle strobe that the block derives by dividing the system clock by twelve. The second is falling transitions on an external count pin, which is looked at once per machine cycle. When the count passes 0xFFFF it does not return to zero. It takes its new value from a separate 16-bit reload pair, leaves that pair untouched, and raises an overflow flag. With the flag and an enable input, the block drives an interrupt request.

Counting starts only when software sets a run bit. A gating option can also make counting depend on the first external-interrupt pin being high, so the block can measure how long that pin stays high. The same control byte holds the trigger-mode bit and the pending flag for two external-interrupt pins. Each pin is either level sensitive, where the flag mirrors the inverted pin, or falling-edge triggered, where the flag is held until acknowledged.

Software reaches five byte-wide registers through a write port and a separate combinational read port. Interrupt acknowledges come from the core's vectoring logic.

Top module: `reload_timer16`

## Requirements
- R1: After synchronous reset every register reads 0x00 and `ovf_irq` is low. The timer is then stopped, in clock mode, ungated, with both interrupt pins level sensitive.
- R2: With run=1, gate=0 and source select=0, the count advances by exactly one for every 12 clock cycles that run is set. With run=0 and no write, the count holds.
- R3: With source select=1, the count advances once for each 1-to-0 change of `cnt_pin` between successive machine-cycle samples. This requires each pin level to be held for at least two machine cycles (24 clocks). Machine cycles without such a change leave the count unchanged.
- R4: With the gate bit set, the count advances only while the synchronized `xint0_pin` is high. While that pin is low, the count holds even with run=1.
- R5: An advance from 0xFFFF loads the count from the reload pair, and the reload pair keeps its value.
- R6: The overflow flag (control bit 5) is set by an advance from 0xFFFF and cleared by `ovf_ack`; a set in the same cycle wins over the acknowledge. `ovf_irq` is high exactly when the flag is set and `irq_en` is high.
- R7: Register map. Address 0 is count low, 1 is count high, 2 is reload low, 3 is reload high and 4 is control; addresses 5 to 7 read 0x00. Control bits from 7 down to 0 are: gate, source select, overflow flag, run, pin-0 flag, pin-0 edge mode, pin-1 flag, pin-1 edge mode. The three flag bits are read-only.
- R8: With its edge-mode bit at 0, a pin's flag equals the inverse of the synchronized pin level.
- R9: With its edge-mode bit at 1, a pin's flag is set by a falling edge of the synchronized pin and kept until that pin's acknowledge. A rising edge does not change it.
- R10: A write to either count byte in a cycle where an advance would occur loads the written byte, and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cnt_pin | input | 1 | External count input (asynchronous) |
| xint0_pin | input | 1 | External interrupt 0 and gate input (asynchronous) |
| xint1_pin | input | 1 | External interrupt 1 (asynchronous) |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| xint0_ack | input | 1 | Interrupt 0 acknowledge (edge mode) |
| xint1_ack | input | 1 | Interrupt 1 acknowledge (edge mode) |
| irq_en | input | 1 | Overflow interrupt enable |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A wrong prescaler phase or divide ratio cannot be seen within a single read. It shows after a run window of a whole number of machine cycles, as a count off by at least one. A count or reload fault appears at the first overflow, as a wrong count value, a changed reload byte or a missing flag, and `ovf_irq` reflects it in the same cycle as the flag. Synchronizer or edge-detector faults show within three clocks of a pin change, as a wrong flag bit in the control byte. A broken write priority shows as a count byte that differs from the value written on the very next read.

// File: rtl/rtmr_pkg.sv
// Package: shared constants for the reload timer.
// Holds the register addresses and control bit positions. The control bit
// order matters to software that decodes the byte, so it is fixed here.
package rtmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;
    localparam int N_XINT = 2;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

    localparam int B_GATE = 7;
    localparam int B_EXT  = 6;
    localparam int B_OVF  = 5;
    localparam int B_RUN  = 4;

    // Flag bit of external interrupt i (pin 0 -> bit 3, pin 1 -> bit 1).
    function automatic int xflag_bit(input int i);
        return 3 - 2 * i;
    endfunction

    // Edge-mode bit of external interrupt i (pin 0 -> bit 2, pin 1 -> bit 0).
    function automatic int xedge_bit(input int i);
        return 2 - 2 * i;
    endfunction
endpackage

// File: rtl/rtmr_prescale.sv
// Module: rtmr_prescale
// Free-running divide-by-DIV counter. It gives a one-clock strobe once per
// machine cycle. Assumes DIV >= 2. It runs from reset whether or not the
// timer is enabled, so the sampling phase never depends on software.
module rtmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ph_q;

    // Step the phase counter and wrap it after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)            ph_q <= '0;
        else if (ph_q == LAST) ph_q <= '0;
        else                   ph_q <= ph_q + 1'b1;
    end

    assign strobe = (ph_q == LAST);
endmodule

// File: rtl/rtmr_pin_sync.sv
// Module: rtmr_pin_sync
// Brings an asynchronous pin into the clock domain through STAGES flops and
// flags a falling edge of the synchronized level. Assumes STAGES >= 2 and a
// pin that idles high, so every flop resets to 1 and reset creates no edge.
module rtmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], pin};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    assign lvl  = sh_q[STAGES-1];
    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/rtmr_xint.sv
// Module: rtmr_xint
// Pending flag of one external interrupt. In level mode the flag mirrors
// the inverted synchronized pin and the acknowledge has no effect. In edge
// mode a falling edge sets it, the acknowledge clears it, and a new edge in
// the acknowledge cycle wins. Software cannot write the flag.
module rtmr_xint (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic fall,
    input  logic edge_mode,
    input  logic ack,
    output logic flag
);
    // Update the pending flag according to the trigger mode.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (!edge_mode) flag <= ~lvl;
        else if (fall)      flag <= 1'b1;
        else if (ack)       flag <= 1'b0;
    end
endmodule

// File: rtl/reload_timer16.sv
// Module: reload_timer16
// 16-bit timer/counter with a reload pair, a gate input and the
// configuration of two external interrupts. It counts machine-cycle strobes
// or falling transitions of cnt_pin, the latter sampled once per machine
// cycle. Assumes software writes one byte per cycle and the pins are
// asynchronous.
module reload_timer16
    import rtmr_pkg::*;
#(
    parameter int PRESC_DIV   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              cnt_pin,
    input  logic              xint0_pin,
    input  logic              xint1_pin,
    input  logic              ovf_ack,
    input  logic              xint0_ack,
    input  logic              xint1_ack,
    input  logic              irq_en,
    output logic              ovf_irq
);
    logic              strobe;
    logic              t_lvl, t_fall_unused, t_prev_q;
    logic [CNT_W-1:0]  cnt_q, rld_q;
    logic              gate_q, ext_q, run_q, ovf_q;
    logic [N_XINT-1:0] x_pin, x_ack, x_lvl, x_fall, x_edge_q, x_flag;
    logic              ctrl_wr, cnt_wr_lo, cnt_wr_hi, cnt_wr;
    logic              tick, cnt_en, inc, wrap;
    logic [BYTE_W-1:0] ctrl_v;

    assign x_pin = {xint1_pin, xint0_pin};
    assign x_ack = {xint1_ack, xint0_ack};

    rtmr_prescale #(.DIV(PRESC_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .strobe(strobe)
    );

    rtmr_pin_sync #(.STAGES(SYNC_STAGES)) u_tsync (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin),
        .lvl(t_lvl), .fall(t_fall_unused)
    );

    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign cnt_wr_lo = wr_en && (wr_addr == A_CNT_LO);
    assign cnt_wr_hi = wr_en && (wr_addr == A_CNT_HI);
    assign cnt_wr    = cnt_wr_lo || cnt_wr_hi;

    // One synchronizer, edge mode bit and flag per external interrupt.
    for (genvar i = 0; i < N_XINT; i++) begin : g_xint
        localparam int EB = xedge_bit(i);

        rtmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin(x_pin[i]),
            .lvl(x_lvl[i]), .fall(x_fall[i])
        );

        // Hold the trigger mode that software selects.
        always_ff @(posedge clk) begin
            if (!rst_n)       x_edge_q[i] <= 1'b0;
            else if (ctrl_wr) x_edge_q[i] <= wr_data[EB];
        end

        rtmr_xint u_flag (
            .clk(clk), .rst_n(rst_n), .lvl(x_lvl[i]), .fall(x_fall[i]),
            .edge_mode(x_edge_q[i]), .ack(x_ack[i]), .flag(x_flag[i])
        );
    end

    // Sample the count pin once per machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      t_prev_q <= 1'b0;
        else if (strobe) t_prev_q <= t_lvl;
    end

    assign tick   = ext_q ? (strobe && t_prev_q && !t_lvl) : strobe;
    assign cnt_en = run_q && (!gate_q || x_lvl[0]);
    assign inc    = cnt_en && tick && !cnt_wr;
    assign wrap   = inc && (cnt_q == {CNT_W{1'b1}});

    // Software-written control bits (the flags are read-only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            ext_q  <= 1'b0;
            run_q  <= 1'b0;
        end else if (ctrl_wr) begin
            gate_q <= wr_data[B_GATE];
            ext_q  <= wr_data[B_EXT];
            run_q  <= wr_data[B_RUN];
        end
    end

    // Count pair: a write wins, then reload on wrap, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            if (cnt_wr_lo) cnt_q[BYTE_W-1:0]     <= wr_data;
            if (cnt_wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wr_data;
        end else if (wrap) begin
            cnt_q <= rld_q;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Reload pair, changed only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_RLD_LO) rld_q[BYTE_W-1:0]     <= wr_data;
            if (wr_addr == A_RLD_HI) rld_q[CNT_W-1:BYTE_W] <= wr_data;
        end
    end

    // Overflow flag: set on wrap, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (wrap)    ovf_q <= 1'b1;
        else if (ovf_ack) ovf_q <= 1'b0;
    end

    assign ovf_irq = ovf_q && irq_en;

    // Assemble the control byte from its fields.
    always_comb begin
        ctrl_v         = '0;
        ctrl_v[B_GATE] = gate_q;
        ctrl_v[B_EXT]  = ext_q;
        ctrl_v[B_OVF]  = ovf_q;
        ctrl_v[B_RUN]  = run_q;
        for (int i = 0; i < N_XINT; i++) begin
            ctrl_v[xflag_bit(i)] = x_flag[i];
            ctrl_v[xedge_bit(i)] = x_edge_q[i];
        end
    end

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CNT_LO: rd_data = cnt_q[BYTE_W-1:0];
            A_CNT_HI: rd_data = cnt_q[CNT_W-1:BYTE_W];
            A_RLD_LO: rd_data = rld_q[BYTE_W-1:0];
            A_RLD_HI: rd_data = rld_q[CNT_W-1:BYTE_W];
            A_CTRL:   rd_data = ctrl_v;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtmr_checker.sv
// Module: rtmr_checker
// Temporal checks on the reload timer, attached by bind. It only observes.
module rtmr_checker
    import rtmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  rld_q,
    input logic              run_q,
    input logic              gate_q,
    input logic              inc,
    input logic              cnt_wr,
    input logic              ovf_q,
    input logic              ovf_ack,
    input logic [N_XINT-1:0] x_lvl,
    input logic [N_XINT-1:0] x_edge_q,
    input logic [N_XINT-1:0] x_flag
);
    // R2: a stopped timer keeps its count unless software writes it.
    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cnt_wr) |=> $stable(cnt_q));

    // R4: a low gate pin freezes the count.
    a_r4_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && !x_lvl[0] && !cnt_wr) |=> $stable(cnt_q));

    // R5: an advance from all ones lands on the reload value.
    a_r5_reload_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (cnt_q == {CNT_W{1'b1}})) |=> (cnt_q == $past(rld_q)));

    // R5: the reload pair only changes through a write.
    a_r5_reload_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rld_q));

    // R6: the overflow flag rises only after a wrap.
    a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(inc && (cnt_q == {CNT_W{1'b1}})));

    // R6: an acknowledge without a wrap clears the flag.
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack && !(inc && (cnt_q == {CNT_W{1'b1}}))) |=> !ovf_q);

    // R8: in level mode pin 1's flag tracks the inverted pin.
    a_r8_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !x_edge_q[1] |=> (x_flag[1] == !$past(x_lvl[1])));

    // R10: a count-low write lands regardless of any increment.
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_CNT_LO)) |=> (cnt_q[BYTE_W-1:0] == $past(wr_data)));
endmodule

bind reload_timer16 rtmr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_q(cnt_q), .rld_q(rld_q), .run_q(run_q),
    .gate_q(gate_q), .inc(inc), .cnt_wr(cnt_wr), .ovf_q(ovf_q),
    .ovf_ack(ovf_ack), .x_lvl(x_lvl), .x_edge_q(x_edge_q), .x_flag(x_flag)
);

// File: tb/tb_reload_timer16.sv
`timescale 1ns/100ps
module tb_reload_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cnt_pin = 1'b1, xint0_pin = 1'b1, xint1_pin = 1'b1;
    logic       ovf_ack = 1'b0, xint0_ack = 1'b0, xint1_ack = 1'b0;
    logic       irq_en = 1'b0;
    logic       ovf_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Scoreboard queues: address (8 = interrupt output), expected value, tag.
    int    qa[$];
    int    qe[$];
    string qt[$];

    localparam int IRQ = 8;

    always #4 clk = ~clk;

    reload_timer16 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_pin(cnt_pin), .xint0_pin(xint0_pin), .xint1_pin(xint1_pin),
        .ovf_ack(ovf_ack), .xint0_ack(xint0_ack), .xint1_ack(xint1_ack),
        .irq_en(irq_en), .ovf_irq(ovf_irq)
    );

    // Monitor: after each edge, pop one expectation and compare.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (qa.size() > 0) begin
                int a, e, act;
                string t;
                a = qa.pop_front();
                e = qe.pop_front();
                t = qt.pop_front();
                if (a != IRQ) rd_addr = a[2:0];
                #1;
                act = (a == IRQ) ? int'(ovf_irq) : int'(rd_data);
                checks++;
                if (act != e) begin
                    errors++;
                    $display("FAIL %s addr %0d: actual 0x%02h expected 0x%02h", t, a, act, e);
                end
            end
        end
    end

    task automatic push(input int a, input int e, input string t);
        qa.push_back(a);
        qe.push_back(e);
        qt.push_back(t);
    endtask

    // Driver: expect a value after the next edge, with nothing driven.
    task automatic chk(input int a, input int e, input string t);
        @(negedge clk);
        push(a, e, t);
        @(posedge clk);
        #3.5;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a[2:0];
        wr_data = d[7:0];
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Run for exactly k machine cycles: control = c | run, then c.
    task automatic run_window(input int c, input int k);
        wr(4, c | 8'h10);
        repeat (12 * k - 1) @(posedge clk);
        wr(4, c);
    endtask

    task automatic set_cnt(input int v);
        wr(0, v & 8'hFF);
        wr(1, (v >> 8) & 8'hFF);
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of every register and the request.
        for (int a = 0; a < 6; a++) chk(a, 0, "R1");
        chk(IRQ, 0, "R1");

        // R7: register map read-back.
        wr(2, 8'h34); wr(3, 8'h12);
        set_cnt(16'h0100);
        chk(2, 8'h34, "R7");
        chk(3, 8'h12, "R7");
        chk(0, 8'h00, "R7");
        chk(1, 8'h01, "R7");
        wr(4, 8'h45);
        chk(4, 8'h45, "R7");
        chk(7, 8'h00, "R7");
        wr(4, 8'h00);

        // R2: clock mode counts one per 12 clocks, holds when stopped.
        run_window(8'h00, 5);
        chk(0, 8'h05, "R2");
        wait_clk(30);
        chk(0, 8'h05, "R2");
        chk(1, 8'h01, "R2");

        // R5/R6: overflow reloads and raises the flag.
        set_cnt(16'hFFFE);
        run_window(8'h00, 3);
        chk(0, 8'h35, "R5");
        chk(1, 8'h12, "R5");
        chk(2, 8'h34, "R5");
        chk(3, 8'h12, "R5");
        chk(4, 8'h20, "R6");
        chk(IRQ, 0, "R6");
        irq_en = 1'b1;
        chk(IRQ, 1, "R6");
        @(negedge clk) ovf_ack = 1'b1;
        @(posedge clk) #1 ovf_ack = 1'b0;
        chk(4, 8'h00, "R6");
        chk(IRQ, 0, "R6");

        // R4: gate pin low freezes the count, high lets it run.
        set_cnt(16'h0200);
        xint0_pin = 1'b0;
        wait_clk(6);
        run_window(8'h80, 4);
        chk(0, 8'h00, "R4");
        chk(4, 8'h88, "R4");
        xint0_pin = 1'b1;
        wait_clk(6);
        run_window(8'h80, 3);
        chk(0, 8'h03, "R4");
        chk(1, 8'h02, "R4");
        wr(4, 8'h00);

        // R8: level mode mirrors the inverted pin; acknowledge has no effect.
        xint1_pin = 1'b0;
        wait_clk(5);
        chk(4, 8'h02, "R8");
        @(negedge clk) xint1_ack = 1'b1;
        @(posedge clk) #1 xint1_ack = 1'b0;
        chk(4, 8'h02, "R8");
        xint1_pin = 1'b1;
        wait_clk(5);
        chk(4, 8'h00, "R8");

        // R9: edge mode latches the falling edge until acknowledge.
        wr(4, 8'h01);
        xint1_pin = 1'b0;
        wait_clk(6);
        chk(4, 8'h03, "R9");
        xint1_pin = 1'b1;
        wait_clk(6);
        chk(4, 8'h03, "R9");
        @(negedge clk) xint1_ack = 1'b1;
        @(posedge clk) #1 xint1_ack = 1'b0;
        chk(4, 8'h01, "R9");
        wait_clk(6);
        chk(4, 8'h01, "R9");
        wr(4, 8'h04);
        xint0_pin = 1'b0;
        wait_clk(6);
        chk(4, 8'h0C, "R9");
        xint0_pin = 1'b1;
        @(negedge clk) xint0_ack = 1'b1;
        @(posedge clk) #1 xint0_ack = 1'b0;
        wait_clk(6);
        chk(4, 8'h04, "R9");
        wr(4, 8'h00);

        // R3: external mode counts falling transitions only.
        set_cnt(16'h0000);
        wr(4, 8'h50);
        wait_clk(40);
        chk(0, 8'h00, "R3");
        for (int n = 0; n < 5; n++) begin
            @(negedge clk) cnt_pin = 1'b0;
            wait_clk(30);
            @(negedge clk) cnt_pin = 1'b1;
            wait_clk(30);
        end
        wait_clk(40);
        wr(4, 8'h40);
        chk(0, 8'h05, "R3");
        chk(1, 8'h00, "R3");

        // R10: back-to-back count writes win over every increment.
        wr(4, 8'h10);
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = 3'd0;
            wr_data = 8'h50;
            push(0, 8'h50, "R10");
            @(posedge clk);
        end
        #1 wr_en = 1'b0;
        wr(4, 8'h00);
        wait_clk(2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule